// File: doc/BRIEF.md
# Loss-of-Signal Qualifier with Edge Masking and Threshold Selection

This block sits between an analog amplitude detector and the rest of a receiver. It takes the raw loss-of-signal comparator bit, which arrives asynchronously, and brings it into the clock domain through a two-flop synchroniser. It then produces a qualified loss-of-signal output. Each direction of output change can start an optional masking interval. During that interval the output keeps its new level and disregards the detector. This hides the chatter that appears just after a signal drops out or comes back.

The same block also supplies the detector with its trip setting. That setting is a 7-bit threshold code and a range bit. The code is either a fixed default or a code taken from a configuration byte.

The masking duration is `(code + 1) * UNIT_TICKS` periods of an external microsecond tick. With `UNIT_TICKS = 16`, code 0 gives 16 µs and code 127 gives 2.048 ms.

A four-state machine drives the output:
- `ST_LOS_ON`: asserted, following the input.
- `ST_LOS_OFF`: deasserted, following the input.
- `ST_HOLD_ON`: asserted and masked.
- `ST_HOLD_OFF`: deasserted and masked.

The transitions are:
- **fall**: `ST_LOS_ON` to `ST_LOS_OFF` or `ST_HOLD_OFF`, when the synchronised input is low.
- **rise**: `ST_LOS_OFF` to `ST_LOS_ON` or `ST_HOLD_ON`, when the synchronised input is high.
- **expire-stay**: a hold state goes to its own following state, when the timer has run out and the input agrees with the held level.
- **expire-flip**: a hold state goes to the opposite following state or the opposite hold state, when the timer has run out and the input disagrees.

Top module: `los_qualifier`

## Requirements
- R1: On reset `los_o` is 1 and the mask timer is cleared, so the first unmasked falling edge after reset reaches `los_o` with no extra delay.
- R2: `range_o` equals `range_bit_i` (1 = high assert range, about 35–80 mVp-p; 0 = low range, about 15–35 mVp-p).
- R3: When `thr_cfg_i[7]` is 1, `thr_code_o` equals `thr_cfg_i[6:0]`. When it is 0, `thr_code_o` equals `DEFAULT_CODE` (64 by default, about 25 mVp-p), whatever `thr_cfg_i[6:0]` holds.
- R4: A change on `los_raw_i` set up before clock edge k appears on `los_o` after edge k+2. These are the two synchroniser flops plus the state register, and the timing is the same whether or not that edge is masked.
- R5: With `rise_mask_i[7]` = 1, after `los_o` rises it stays 1 for exactly `(rise_mask_i[6:0]+1)*UNIT_TICKS` ticks, whatever `los_raw_i` does. It leaves the hold on the clock edge after the last of those ticks.
- R6: With `fall_mask_i[7]` = 1, after `los_o` falls it stays 0 for exactly `(fall_mask_i[6:0]+1)*UNIT_TICKS` ticks, whatever `los_raw_i` does.
- R7: When a hold expires, `los_o` keeps its level if the synchronised input agrees with it. If the input disagrees, `los_o` changes at once, and that change starts the opposite edge's hold if the opposite edge is enabled.
- R8: The duration code is captured when a hold starts, so changing the mask byte during a hold does not alter that hold's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle microsecond tick pulse |
| los_raw_i | input | 1 | Raw detector output, asynchronous, 1 = signal lost |
| range_bit_i | input | 1 | Detector range select configuration bit |
| thr_cfg_i | input | 8 | [7] use programmed code, [6:0] programmed threshold code |
| fall_mask_i | input | 8 | [7] falling-edge mask enable, [6:0] falling-edge duration code |
| rise_mask_i | input | 8 | [7] rising-edge mask enable, [6:0] rising-edge duration code |
| los_o | output | 1 | Qualified loss-of-signal output |
| thr_code_o | output | 7 | Threshold code to the detector |
| range_o | output | 1 | Range select to the detector |

## Verification
The bench builds the block with `UNIT_TICKS = 2` and a tick every four clocks. This brings a masking interval down to a few dozen cycles, so duration codes 0 to 31 plus 64 and 127 can be swept for both edge directions. Each sweep counts ticks between the two output changes and compares the count with `(code+1)*2`. All 128 programmed threshold codes, and the default path, are swept exhaustively. Further scenarios cover holds that expire into agreement, holds that chain into the opposite edge's hold, a mask byte rewritten mid-hold, and reset during a hold.

// File: rtl/los_pkg.sv
package los_pkg;

    localparam int DUR_W = 7;

    typedef enum logic [1:0] {
        ST_LOS_ON   = 2'd0,
        ST_LOS_OFF  = 2'd1,
        ST_HOLD_ON  = 2'd2,
        ST_HOLD_OFF = 2'd3
    } los_state_e;

    typedef struct packed {
        logic             en;
        logic [DUR_W-1:0] dur;
    } mask_cfg_t;

endpackage

// File: rtl/los_sync.sv
module los_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] ff_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) ff_q[0] <= RST_VAL;
                    else     ff_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) ff_q[s] <= RST_VAL;
                    else     ff_q[s] <= ff_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/los_mask_timer.sv
module los_mask_timer #(
    parameter int DUR_W      = 7,
    parameter int UNIT_TICKS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic [DUR_W-1:0] dur_i,
    output logic             busy_o
);

    localparam int CNT_W = DUR_W + $clog2(UNIT_TICKS) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        load_val = CNT_W'((CNT_W'(dur_i) + CNT_W'(1)) * CNT_W'(UNIT_TICKS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= load_val;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign busy_o = (cnt_q != '0);

    // R5 / R6: a load always yields a nonzero count, so a started hold is busy
    a_r5_start_busy : assert property (@(posedge clk) disable iff (rst)
        start_i |=> busy_o);

    // R5 / R6: without a new start the count never grows
    a_r6_no_growth : assert property (@(posedge clk) disable iff (rst)
        (!start_i && busy_o) |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/los_thresh_sel.sv
module los_thresh_sel #(
    parameter int CODE_W       = 7,
    parameter int DEFAULT_CODE = 64
) (
    input  logic [CODE_W:0]   cfg_i,
    input  logic              range_bit_i,
    output logic [CODE_W-1:0] code_o,
    output logic              range_o
);

    localparam logic [CODE_W-1:0] DEF_CODE = CODE_W'(DEFAULT_CODE);

    always_comb begin
        if (cfg_i[CODE_W]) code_o = cfg_i[CODE_W-1:0];
        else               code_o = DEF_CODE;
        range_o = range_bit_i;
    end

endmodule

// File: rtl/los_qualifier.sv
module los_qualifier
    import los_pkg::*;
#(
    parameter int UNIT_TICKS   = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int DEFAULT_CODE = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             los_raw_i,
    input  logic             range_bit_i,
    input  logic [DUR_W:0]   thr_cfg_i,
    input  logic [DUR_W:0]   fall_mask_i,
    input  logic [DUR_W:0]   rise_mask_i,
    output logic             los_o,
    output logic [DUR_W-1:0] thr_code_o,
    output logic             range_o
);

    mask_cfg_t        rise_cfg, fall_cfg;
    logic             los_sync;
    logic             tmr_busy;
    logic             tmr_start;
    logic [DUR_W-1:0] tmr_dur;
    los_state_e       state_q, state_d;

    assign rise_cfg = mask_cfg_t'(rise_mask_i);
    assign fall_cfg = mask_cfg_t'(fall_mask_i);

    los_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (los_raw_i),
        .q_o (los_sync)
    );

    los_mask_timer #(
        .DUR_W      (DUR_W),
        .UNIT_TICKS (UNIT_TICKS)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .start_i (tmr_start),
        .dur_i   (tmr_dur),
        .busy_o  (tmr_busy)
    );

    los_thresh_sel #(
        .CODE_W       (DUR_W),
        .DEFAULT_CODE (DEFAULT_CODE)
    ) thr_i (
        .cfg_i       (thr_cfg_i),
        .range_bit_i (range_bit_i),
        .code_o      (thr_code_o),
        .range_o     (range_o)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOS_ON;
        else     state_q <= state_d;
    end

    // next-state logic: rise, fall, expire-stay, expire-flip
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOS_ON: begin
                if (!los_sync) state_d = fall_cfg.en ? ST_HOLD_OFF : ST_LOS_OFF;
            end
            ST_LOS_OFF: begin
                if (los_sync) state_d = rise_cfg.en ? ST_HOLD_ON : ST_LOS_ON;
            end
            ST_HOLD_ON: begin
                if (!tmr_busy) begin
                    if (!los_sync) state_d = fall_cfg.en ? ST_HOLD_OFF : ST_LOS_OFF;
                    else           state_d = ST_LOS_ON;
                end
            end
            ST_HOLD_OFF: begin
                if (!tmr_busy) begin
                    if (los_sync) state_d = rise_cfg.en ? ST_HOLD_ON : ST_LOS_ON;
                    else          state_d = ST_LOS_OFF;
                end
            end
            default: state_d = ST_LOS_ON;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        tmr_start = 1'b0;
        tmr_dur   = rise_cfg.dur;
        unique case (state_q)
            ST_LOS_ON, ST_HOLD_ON:   los_o = 1'b1;
            ST_LOS_OFF, ST_HOLD_OFF: los_o = 1'b0;
            default:                 los_o = 1'b1;
        endcase
        if ((state_d == ST_HOLD_ON) && (state_q != ST_HOLD_ON)) begin
            tmr_start = 1'b1;
            tmr_dur   = rise_cfg.dur;
        end else if ((state_d == ST_HOLD_OFF) && (state_q != ST_HOLD_OFF)) begin
            tmr_start = 1'b1;
            tmr_dur   = fall_cfg.dur;
        end
    end

    // R5 / R6: the output does not move while a masking interval runs
    a_r5_hold_stable : assert property (@(posedge clk) disable iff (rst)
        tmr_busy |=> $stable(los_o));

    // R4 / R7: every output change adopts the synchronised input level
    a_r7_follow_sync : assert property (@(posedge clk) disable iff (rst)
        !$stable(los_o) |-> (los_o == $past(los_sync)));

    // R5 / R6: a masking interval starts only for an enabled edge direction
    a_r6_enabled_edge : assert property (@(posedge clk) disable iff (rst)
        $rose(tmr_busy) |-> (los_o ? $past(rise_cfg.en) : $past(fall_cfg.en)));

    // R7: the timer only runs while the machine sits in a hold state
    a_r7_busy_in_hold : assert property (@(posedge clk) disable iff (rst)
        tmr_busy |-> ((state_q == ST_HOLD_ON) || (state_q == ST_HOLD_OFF)));

endmodule

// File: tb/los_qualifier_tb.sv
module los_qualifier_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int UNIT       = 2;
    localparam int TICK_EVERY = 4;
    localparam int DEF_CODE   = 64;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       raw = 1'b1;
    logic       range_bit = 1'b0;
    logic [7:0] thr_cfg = 8'h00;
    logic [7:0] fall_mask = 8'h00;
    logic [7:0] rise_mask = 8'h00;
    logic       los;
    logic [6:0] thr_code;
    logic       range_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int tick_ph = 0;

    los_qualifier #(
        .UNIT_TICKS   (UNIT),
        .SYNC_STAGES  (2),
        .DEFAULT_CODE (DEF_CODE)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick),
        .los_raw_i   (raw),
        .range_bit_i (range_bit),
        .thr_cfg_i   (thr_cfg),
        .fall_mask_i (fall_mask),
        .rise_mask_i (rise_mask),
        .los_o       (los),
        .thr_code_o  (thr_code),
        .range_o     (range_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        tick_ph <= (tick_ph + 1) % TICK_EVERY;
        tick    <= (tick_ph == TICK_EVERY - 2);
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive los_raw to tgt; returns edges until los_o followed and tick count of the hold
    task automatic run_hold(input bit tgt, input bit flip_back, input bit mid_change,
                            output int lat, output int tcnt);
        int guard;
        lat = 0;
        tcnt = 0;
        @(negedge clk);
        raw = tgt;
        while (los != tgt && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        if (flip_back) raw = !tgt;
        tcnt = int'(tick);
        guard = 0;
        forever begin
            @(negedge clk);
            guard++;
            if (los != tgt || guard > 5000) break;
            tcnt += int'(tick);
            if (mid_change && guard == 3) begin
                rise_mask[6:0] = rise_mask[6:0] ^ 7'h55;
                fall_mask[6:0] = fall_mask[6:0] ^ 7'h55;
            end
        end
    endtask

    task automatic hold_sweep(input bit rise, input int code, input bit mid_change);
        int lat, tcnt, exp;
        exp = (code + 1) * UNIT;
        if (rise) begin
            rise_mask = {1'b1, 7'(code)};
            fall_mask = 8'h00;
        end else begin
            fall_mask = {1'b1, 7'(code)};
            rise_mask = 8'h00;
        end
        run_hold(rise, 1'b1, mid_change, lat, tcnt);
        chk(lat == 3, "R4 masked edge latency", lat, 3);
        if (mid_change)
            chk(tcnt == exp, "R8 snapshot duration", tcnt, exp);
        else if (rise)
            chk(tcnt == exp, "R5 rise hold ticks", tcnt, exp);
        else
            chk(tcnt == exp, "R6 fall hold ticks", tcnt, exp);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int lat, tcnt;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(los == 1'b1, "R1 reset los", int'(los), 1);

        // R2: range pass-through
        for (int r = 0; r < 2; r++) begin
            range_bit = r[0];
            #1;
            chk(range_out == r[0], "R2 range", int'(range_out), r);
        end

        // R3: exhaustive threshold code sweep
        for (int c = 0; c < 128; c++) begin
            thr_cfg = {1'b1, 7'(c)};
            #1;
            chk(thr_code == 7'(c), "R3 programmed code", int'(thr_code), c);
            thr_cfg = {1'b0, 7'(c)};
            #1;
            chk(thr_code == 7'(DEF_CODE), "R3 default code", int'(thr_code), DEF_CODE);
        end

        // R4 and R1: unmasked fall right after reset, then unmasked rise
        @(negedge clk);
        raw = 1'b0;
        @(negedge clk);
        chk(los == 1'b1, "R4 fall edge+0", int'(los), 1);
        @(negedge clk);
        chk(los == 1'b1, "R4 fall edge+1", int'(los), 1);
        @(negedge clk);
        chk(los == 1'b0, "R1 R4 fall edge+2", int'(los), 0);
        raw = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(los == 1'b0, "R4 rise edge+1", int'(los), 0);
        @(negedge clk);
        chk(los == 1'b1, "R4 rise edge+2", int'(los), 1);

        // R6 then R5 sweeps; los starts at 1 for falls
        for (int c = 0; c < 32; c++) hold_sweep(1'b0, c, 1'b0);
        hold_sweep(1'b0, 64, 1'b0);
        hold_sweep(1'b0, 127, 1'b0);
        fall_mask = 8'h00;
        @(negedge clk);
        raw = 1'b0;
        repeat (5) @(negedge clk);
        for (int c = 0; c < 32; c++) hold_sweep(1'b1, c, 1'b0);
        hold_sweep(1'b1, 64, 1'b0);
        hold_sweep(1'b1, 127, 1'b0);

        // R8: rewrite the mask byte during a rising hold
        hold_sweep(1'b1, 9, 1'b1);

        // R7: expiry with agreeing input keeps the level
        rise_mask = 8'h82;
        fall_mask = 8'h00;
        run_hold(1'b1, 1'b0, 1'b0, lat, tcnt);
        repeat (3 * UNIT * TICK_EVERY + 20) @(negedge clk);
        chk(los == 1'b1, "R7 expire agree", int'(los), 1);
        raw = 1'b0;
        repeat (3) @(negedge clk);
        chk(los == 1'b0, "R7 follow after expiry", int'(los), 0);

        // R7: expiry with disagreeing input chains into the falling hold
        rise_mask = 8'h81;
        fall_mask = 8'h83;
        run_hold(1'b1, 1'b1, 1'b0, lat, tcnt);
        chk(tcnt == 2 * UNIT, "R7 first hold", tcnt, 2 * UNIT);
        chk(los == 1'b0, "R7 chained flip", int'(los), 0);
        raw = 1'b1;
        tcnt = int'(tick);
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            if (los != 1'b0) break;
            tcnt += int'(tick);
        end
        chk(tcnt == 4 * UNIT, "R7 chained fall hold", tcnt, 4 * UNIT);

        // R1: reset during a hold clears the timer
        rise_mask = 8'h00;
        fall_mask = 8'h00;
        raw = 1'b0;
        repeat (6) @(negedge clk);
        rise_mask = 8'hFF;
        raw = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rise_mask = 8'h00;
        chk(los == 1'b1, "R1 reset in hold", int'(los), 1);
        raw = 1'b0;
        repeat (3) @(negedge clk);
        chk(los == 1'b0, "R1 timer cleared", int'(los), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule